// File: doc/BRIEF.md
# Hardware Genetic Evolution Controller

This block runs a small evolutionary search over the configuration chromosome of a virtual reconfigurable circuit. After a start pulse it takes a seed chromosome as the first "best" solution. It then produces candidates by flipping one randomly chosen bit of the current best. Each candidate is stored in one of four chromosome memories and written word by word into the circuit's configuration memory. The controller then raises a request and waits for an external evaluator to return a fitness value.

Every returned fitness is latched in the fitness register of that individual and compared with the fitness of the best. Only a strictly larger value replaces the best, so ties never cause drift. After the requested number of generations (four candidates each), the best chromosome is written back into the circuit and a one-cycle completion pulse is given. The best chromosome and its fitness stay visible on outputs. The search sequence comes from a free-running 16-bit LFSR, reduced modulo the chromosome length.

Top module: `gen_evo_ctrl`

## Requirements
- R1: After reset, busy, done, fit_req and cfg_we are all low.
- R2: A start pulse in idle runs gen_limit generations of four candidates each, so exactly 4*gen_limit fitness requests are raised.
- R3: Each candidate written to the circuit differs in exactly one bit from the best chromosome held at the moment it was created.
- R4: Each configuration load writes CFG_WORDS words at ascending addresses 0,1,2,... with cfg_we high; word k carries chromosome bits [k*WORD_W +: WORD_W], and bits above CHROM_W in the last word are zero.
- R5: fit_req stays high until fit_valid is sampled high; fit_valid while fit_req is low has no effect on best_fit or best_chrom.
- R6: A candidate replaces the best only when its fitness is strictly greater than best_fit; equal fitness keeps the existing best. best_fit starts at 0 on every start.
- R7: After the last generation, the best chromosome is reloaded into the configuration memory, then done is high for exactly one cycle and busy drops in the next cycle.
- R8: With gen_limit equal to 0, no fitness request is made; the seed is loaded and done follows.
- R9: At done, best_chrom and best_fit hold the best chromosome and its fitness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (ignored unless idle) |
| seed_chrom | input | CHROM_W | Initial best chromosome |
| gen_limit | input | GEN_W | Number of generations, sampled at start |
| fit_valid | input | 1 | Fitness value is valid |
| fit_value | input | FIT_W | Fitness of the candidate under test |
| fit_req | output | 1 | Candidate loaded, fitness awaited |
| cfg_we | output | 1 | Configuration memory write enable |
| cfg_addr | output | CFG_AW | Configuration word address |
| cfg_data | output | WORD_W | Configuration word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| best_chrom | output | CHROM_W | Best chromosome found |
| best_fit | output | FIT_W | Fitness of the best chromosome |

## Verification
The hard part is the mutation site, which comes from an internal LFSR and cannot be steered from the ports. The bench therefore rebuilds each candidate from the configuration writes, keeps its own copy of the best, and checks a Hamming distance of one instead of a fixed bit. Tie handling is forced by an evaluator that returns the same nonzero value every time, so only the first candidate may win. A zero evaluator preceded by stray fit_valid pulses in idle shows that the seed survives a whole run.

// File: rtl/evo_pkg.sv
package evo_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_MUTATE  = 3'd1,
      ST_LOAD    = 3'd2,
      ST_WAIT    = 3'd3,
      ST_COMPARE = 3'd4,
      ST_NEXT    = 3'd5,
      ST_DONE    = 3'd6
   } evo_state_e;

   localparam logic [15:0] LFSR_TAPS = 16'hB400;
   localparam logic [15:0] LFSR_INIT = 16'hACE1;

endpackage

// File: rtl/evo_lfsr.sv
module evo_lfsr #(
   parameter int          WIDTH = 16,
   parameter logic [15:0] TAPS  = evo_pkg::LFSR_TAPS,
   parameter logic [15:0] INIT  = evo_pkg::LFSR_INIT
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] rnd
);

   initial begin
      if (WIDTH != 16) $error("evo_lfsr: WIDTH must be 16");
      if (INIT == 16'h0) $error("evo_lfsr: INIT must be nonzero");
   end

   logic [WIDTH-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= INIT;
      end else if (state_q[0]) begin
         state_q <= (state_q >> 1) ^ TAPS;
      end else begin
         state_q <= state_q >> 1;
      end
   end

   assign rnd = state_q;

endmodule

// File: rtl/evo_mutator.sv
module evo_mutator #(
   parameter int CHROM_W = 20,
   parameter int RND_W   = 16,
   parameter int POS_W   = (CHROM_W > 1) ? $clog2(CHROM_W) : 1
) (
   input  logic [RND_W-1:0]   rnd,
   input  logic [CHROM_W-1:0] parent,
   output logic [POS_W-1:0]   pos,
   output logic [CHROM_W-1:0] child
);

   localparam bit POW2 = ((CHROM_W & (CHROM_W - 1)) == 0);

   initial begin
      if (CHROM_W < 2) $error("evo_mutator: CHROM_W must be at least 2");
      if (CHROM_W > (1 << RND_W)) $error("evo_mutator: CHROM_W exceeds random range");
   end

   generate
      if (POW2) begin : g_mask
         assign pos = rnd[POS_W-1:0];
      end else begin : g_mod
         logic [RND_W-1:0] rem;
         assign rem = rnd % RND_W'(CHROM_W);
         assign pos = rem[POS_W-1:0];
      end
   endgenerate

   logic [CHROM_W-1:0] flip_mask;
   assign flip_mask = CHROM_W'(1) << pos;
   assign child     = parent ^ flip_mask;

endmodule

// File: rtl/evo_word_sel.sv
module evo_word_sel #(
   parameter int CHROM_W = 20,
   parameter int WORD_W  = 8,
   parameter int AW      = 2
) (
   input  logic [CHROM_W-1:0] chrom,
   input  logic [AW-1:0]      sel,
   output logic [WORD_W-1:0]  word
);

   localparam int NWORDS = (CHROM_W + WORD_W - 1) / WORD_W;
   localparam int PAD_W  = NWORDS * WORD_W - CHROM_W;

   logic [NWORDS*WORD_W-1:0] padded;

   generate
      if (PAD_W == 0) begin : g_exact
         assign padded = chrom;
      end else begin : g_pad
         assign padded = {{PAD_W{1'b0}}, chrom};
      end
   endgenerate

   always_comb begin
      word = '0;
      for (int k = 0; k < NWORDS; k++) begin
         if (int'(sel) == k) word = padded[k*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/gen_evo_ctrl.sv
module gen_evo_ctrl #(
   parameter int CHROM_W = 20,
   parameter int WORD_W  = 8,
   parameter int CFG_AW  = 2,
   parameter int FIT_W   = 16,
   parameter int GEN_W   = 16,
   parameter int POP     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CHROM_W-1:0] seed_chrom,
   input  logic [GEN_W-1:0]   gen_limit,
   input  logic               fit_valid,
   input  logic [FIT_W-1:0]   fit_value,
   output logic               fit_req,
   output logic               cfg_we,
   output logic [CFG_AW-1:0]  cfg_addr,
   output logic [WORD_W-1:0]  cfg_data,
   output logic               busy,
   output logic               done,
   output logic [CHROM_W-1:0] best_chrom,
   output logic [FIT_W-1:0]   best_fit
);
   import evo_pkg::*;

   localparam int CFG_WORDS = (CHROM_W + WORD_W - 1) / WORD_W;
   localparam int IDX_W     = (POP > 1) ? $clog2(POP) : 1;
   localparam int POS_W     = (CHROM_W > 1) ? $clog2(CHROM_W) : 1;
   localparam int RND_W     = 16;
   localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(POP - 1);
   localparam logic [CFG_AW-1:0] WORD_LAST = CFG_AW'(CFG_WORDS - 1);

   initial begin
      if (POP < 2 || (POP & (POP - 1)) != 0) $error("gen_evo_ctrl: POP must be a power of two >= 2");
      if ((1 << CFG_AW) < CFG_WORDS) $error("gen_evo_ctrl: CFG_AW too narrow for chromosome");
      if (WORD_W < 1 || FIT_W < 1 || GEN_W < 1) $error("gen_evo_ctrl: widths must be positive");
   end

   evo_state_e         state_q;
   logic [IDX_W-1:0]   idx_q;
   logic [CFG_AW-1:0]  word_q;
   logic [GEN_W-1:0]   gen_q;
   logic [GEN_W-1:0]   lim_q;
   logic               reload_q;
   logic [CHROM_W-1:0] best_q;
   logic [FIT_W-1:0]   best_fit_q;
   logic [CHROM_W-1:0] chrom_mem [POP];
   logic [FIT_W-1:0]   fit_reg   [POP];

   logic [RND_W-1:0]   rnd;
   logic [POS_W-1:0]   mut_pos;
   logic [CHROM_W-1:0] mutant;
   logic [CHROM_W-1:0] load_src;
   logic [WORD_W-1:0]  load_word;
   logic               cand_better;
   logic               last_gen;

   evo_lfsr #(.WIDTH(RND_W)) i_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   evo_mutator #(.CHROM_W(CHROM_W), .RND_W(RND_W), .POS_W(POS_W)) i_mut (
      .rnd    (rnd),
      .parent (best_q),
      .pos    (mut_pos),
      .child  (mutant)
   );

   assign load_src = reload_q ? best_q : chrom_mem[idx_q];

   evo_word_sel #(.CHROM_W(CHROM_W), .WORD_W(WORD_W), .AW(CFG_AW)) i_wsel (
      .chrom (load_src),
      .sel   (word_q),
      .word  (load_word)
   );

   assign cand_better = (fit_reg[idx_q] > best_fit_q);
   assign last_gen    = ({1'b0, gen_q} + {{GEN_W{1'b0}}, 1'b1}) == {1'b0, lim_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         idx_q      <= '0;
         word_q     <= '0;
         gen_q      <= '0;
         lim_q      <= '0;
         reload_q   <= 1'b0;
         best_q     <= '0;
         best_fit_q <= '0;
         for (int i = 0; i < POP; i++) begin
            chrom_mem[i] <= '0;
            fit_reg[i]   <= '0;
         end
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  best_q     <= seed_chrom;
                  best_fit_q <= '0;
                  idx_q      <= '0;
                  word_q     <= '0;
                  gen_q      <= '0;
                  lim_q      <= gen_limit;
                  if (gen_limit == '0) begin
                     reload_q <= 1'b1;
                     state_q  <= ST_LOAD;
                  end else begin
                     reload_q <= 1'b0;
                     state_q  <= ST_MUTATE;
                  end
               end
            end
            ST_MUTATE: begin
               chrom_mem[idx_q] <= mutant;
               word_q           <= '0;
               state_q          <= ST_LOAD;
            end
            ST_LOAD: begin
               if (word_q == WORD_LAST) begin
                  word_q  <= '0;
                  state_q <= reload_q ? ST_DONE : ST_WAIT;
               end else begin
                  word_q <= word_q + 1'b1;
               end
            end
            ST_WAIT: begin
               if (fit_valid) begin
                  fit_reg[idx_q] <= fit_value;
                  state_q        <= ST_COMPARE;
               end
            end
            ST_COMPARE: begin
               if (cand_better) begin
                  best_q     <= chrom_mem[idx_q];
                  best_fit_q <= fit_reg[idx_q];
               end
               state_q <= ST_NEXT;
            end
            ST_NEXT: begin
               if (idx_q == IDX_LAST) begin
                  idx_q <= '0;
                  gen_q <= gen_q + 1'b1;
                  if (last_gen) begin
                     reload_q <= 1'b1;
                     word_q   <= '0;
                     state_q  <= ST_LOAD;
                  end else begin
                     state_q <= ST_MUTATE;
                  end
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_MUTATE;
               end
            end
            ST_DONE: begin
               reload_q <= 1'b0;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign fit_req    = (state_q == ST_WAIT);
   assign cfg_we     = (state_q == ST_LOAD);
   assign cfg_addr   = word_q;
   assign cfg_data   = load_word;
   assign busy       = (state_q != ST_IDLE);
   assign done       = (state_q == ST_DONE);
   assign best_chrom = best_q;
   assign best_fit   = best_fit_q;

endmodule

// File: rtl/gen_evo_ctrl_chk.sv
module gen_evo_ctrl_chk #(
   parameter int CHROM_W = 20,
   parameter int WORD_W  = 8,
   parameter int CFG_AW  = 2,
   parameter int FIT_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               fit_valid,
   input logic               fit_req,
   input logic               cfg_we,
   input logic [CFG_AW-1:0]  cfg_addr,
   input logic               busy,
   input logic               done,
   input logic [CHROM_W-1:0] best_chrom,
   input logic [FIT_W-1:0]   best_fit
);
   localparam int CFG_WORDS = (CHROM_W + WORD_W - 1) / WORD_W;
   localparam logic [CFG_AW-1:0] LASTW = CFG_AW'(CFG_WORDS - 1);

   // R7: completion is a single-cycle pulse followed by idle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R5: request is held until fitness arrives
   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (fit_req && !fit_valid) |=> fit_req);

   // R4: configuration words go out back to back at ascending addresses
   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr != LASTW) |=> (cfg_we && cfg_addr == $past(cfg_addr) + 1'b1));

   // R4: a load always begins at address zero
   a_r4_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_we) |-> (cfg_addr == '0));

   // R6: within a run the best fitness never decreases
   a_r6_best_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (best_fit >= $past(best_fit)));

   // R6: best chromosome changes only together with a strictly larger fitness during a run
   a_r6_best_strict: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(best_chrom)) |-> (best_fit > $past(best_fit)));

   // R1: request, write and done are mutually exclusive
   a_r1_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fit_req, cfg_we, done}));

endmodule

bind gen_evo_ctrl gen_evo_ctrl_chk #(
   .CHROM_W(CHROM_W), .WORD_W(WORD_W), .CFG_AW(CFG_AW), .FIT_W(FIT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fit_valid  (fit_valid),
   .fit_req    (fit_req),
   .cfg_we     (cfg_we),
   .cfg_addr   (cfg_addr),
   .busy       (busy),
   .done       (done),
   .best_chrom (best_chrom),
   .best_fit   (best_fit)
);

// File: tb/test_gen_evo_ctrl.sv
`timescale 1ns/1ps
module test_gen_evo_ctrl;
   localparam int CW = 20;
   localparam int WW = 8;
   localparam int AW = 2;
   localparam int FW = 16;
   localparam int GW = 16;
   localparam int NW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] seed_chrom = '0;
   logic [GW-1:0] gen_limit = '0;
   logic          fit_valid = 1'b0;
   logic [FW-1:0] fit_value = '0;
   logic          fit_req, cfg_we, busy, done;
   logic [AW-1:0] cfg_addr;
   logic [WW-1:0] cfg_data;
   logic [CW-1:0] best_chrom;
   logic [FW-1:0] best_fit;

   int nchk = 0;
   int nfail = 0;
   int ncand = 0;
   int mode = 0;
   bit auto_fit = 1'b0;
   int cycles = 0;
   logic [NW*WW-1:0] img;
   logic [AW-1:0]    exp_addr = '0;
   logic [CW-1:0]    exp_best;
   logic [FW-1:0]    exp_bfit;

   always #4 clk = ~clk;

   gen_evo_ctrl #(.CHROM_W(CW), .WORD_W(WW), .CFG_AW(AW), .FIT_W(FW), .GEN_W(GW), .POP(4)) i_gen_evo_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .seed_chrom(seed_chrom), .gen_limit(gen_limit),
      .fit_valid(fit_valid), .fit_value(fit_value), .fit_req(fit_req), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .busy(busy), .done(done),
      .best_chrom(best_chrom), .best_fit(best_fit)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic logic [FW-1:0] eval_fit(input logic [CW-1:0] c);
      case (mode)
         0: return FW'($countones(c));
         1: return FW'(5);
         2: return FW'(0);
         default: return FW'(c[7:0]);
      endcase
   endfunction

   // configuration capture and fitness evaluator
   always @(negedge clk) begin
      if (cfg_we) begin
         chk(cfg_addr == exp_addr, "R4 addr", 32'(cfg_addr), 32'(exp_addr));
         img[cfg_addr*WW +: WW] = cfg_data;
         if (cfg_addr == AW'(NW-1)) begin
            chk(cfg_data[7:4] == 4'h0, "R4 pad", 32'(cfg_data[7:4]), 0);
            exp_addr = '0;
         end else begin
            exp_addr = cfg_addr + 1'b1;
         end
      end
      if (fit_valid && auto_fit) begin
         fit_valid = 1'b0;
      end else if (fit_req && auto_fit) begin
         logic [CW-1:0] cand;
         logic [FW-1:0] f;
         cand = img[CW-1:0];
         ncand++;
         chk($countones(cand ^ exp_best) == 1, "R3 one-bit", 32'(cand), 32'(exp_best));
         f = eval_fit(cand);
         if (f > exp_bfit) begin
            exp_best = cand;
            exp_bfit = f;
         end
         fit_value = f;
         fit_valid = 1'b1;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected=done", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   task automatic run_evo(input logic [CW-1:0] seed, input int lim, input int m, input string tag);
      exp_best   = seed;
      exp_bfit   = '0;
      ncand      = 0;
      mode       = m;
      img        = '1;
      auto_fit   = 1'b1;
      seed_chrom = seed;
      gen_limit  = GW'(lim);
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done) @(negedge clk);
      chk(ncand == 4*lim, {tag, " R2 count"}, 32'(ncand), 32'(4*lim));
      chk(img[CW-1:0] == exp_best, {tag, " R7 reload"}, 32'(img[CW-1:0]), 32'(exp_best));
      chk(best_chrom == exp_best, {tag, " R9 chrom"}, 32'(best_chrom), 32'(exp_best));
      chk(best_fit == exp_bfit, {tag, " R9 fit"}, 32'(best_fit), 32'(exp_bfit));
      @(negedge clk);
      chk(!done && !busy, {tag, " R7 pulse"}, {30'd0, done, busy}, 0);
      auto_fit = 1'b0;
   endtask

   task automatic t_reset;
      chk({busy, done, fit_req, cfg_we} == 4'b0, "R1 reset", 32'({busy, done, fit_req, cfg_we}), 0);
   endtask

   task automatic t_popcount;
      run_evo(20'h0_1234, 3, 0, "popcount");
      chk(best_fit > 0, "R6 improved", 32'(best_fit), 1);
   endtask

   task automatic t_ties;
      // constant fitness: only the first candidate may win (R6)
      run_evo(20'hA_5A5A, 2, 1, "ties");
   endtask

   task automatic t_bytefit;
      run_evo(20'hF_0F00, 4, 3, "byte");
   endtask

   task automatic t_zero_limit;
      run_evo(20'h5_C3A1, 0, 0, "R8 zero");
      chk(img[CW-1:0] == 20'h5_C3A1, "R8 seed", 32'(img[CW-1:0]), 32'h5C3A1);
   endtask

   task automatic t_stray_valid;
      logic [FW-1:0] held;
      held = best_fit;
      fit_value = '1;
      fit_valid = 1'b1;
      repeat (3) @(negedge clk);
      fit_valid = 1'b0;
      @(negedge clk);
      chk(best_fit == held, "R5 stray fit", 32'(best_fit), 32'(held));
      chk(!busy && !fit_req, "R5 idle", 32'({busy, fit_req}), 0);
      run_evo(20'h3_3333, 2, 2, "R5 zerofit");
      chk(best_chrom == 20'h3_3333, "R6 seed kept", 32'(best_chrom), 32'h33333);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_popcount();
      t_ties();
      t_bytefit();
      t_zero_limit();
      t_stray_valid();
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule